// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. A load strobe captures a full external start address and presents it unchanged on the registered output. Each following advance strobe moves the two low address bits to the next beat, while the upper bits stay equal to those of the captured start address. The beat count wraps inside the four-beat window, so a burst that runs past its fourth beat begins the same four addresses again.

Two orders are available. In linear order the low bits count up modulo four from the start value. In interleaved order each beat is the start's low bits XORed with the beat number. The order is taken from a strap input that is sampled while reset is held and then ignored. A clock-enable input freezes every register, and while it is low the other synchronous inputs have no effect.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low on a rising edge, the output address, the captured start and the beat number all become zero. An advance right after reset in linear order therefore gives address 1.
- R2: When `clk_en` is high and `load_n` is low on a rising edge, `burst_addr` equals `ext_addr` (all bits) from that edge onward, and the beat number restarts at zero.
- R3: With linear order (`order_sel` = 0 at reset), each advance (`clk_en` high, `load_n` high) sets the two low bits to (start + beat) mod 4. Start 01 gives 01, 10, 11, 00.
- R4: With interleaved order (`order_sel` = 1 at reset), each advance sets the two low bits to start XOR beat. Start 01 gives 01, 00, 11, 10, and start 10 gives 10, 11, 00, 01.
- R5: The fourth advance after a load brings `burst_addr` back to the loaded start address. Later advances repeat the same four-beat cycle.
- R6: During advances the bits above the low two equal those of the captured start address, and `ext_addr` has no effect.
- R7: While `clk_en` is low, `burst_addr` and the beat position hold their values, and `load_n` and `ext_addr` are ignored. An advance after `clk_en` returns continues from the held beat.
- R8: `order_sel` is sampled on every rising edge while `rst_n` is low. A change after reset has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | High enables the registers. Low freezes all state |
| load_n | input | 1 | Low loads a start address. High advances one beat |
| order_sel | input | 1 | Burst order strap: 0 linear, 1 interleaved. Sampled during reset |
| ext_addr | input | ADDR_W | External start address |
| burst_addr | output | ADDR_W | Registered burst beat address |

## Verification
The bench drives start values whose low bits differ, so that an adder used in place of an XOR, or the reverse, shows up at the second beat. It runs five or more advances after a load, because a counter that does not wrap, or that wraps to zero instead of to the start, fails at the fifth beat. While the block is frozen the bench changes `ext_addr` and pulses `load_n`, which catches a missing clock-enable gate as a jump in the held address. After reset it toggles `order_sel`, which catches a design that follows the strap live as an order change in the middle of a burst.

// File: rtl/bseq_pkg.sv
// Package: shared types of the burst address sequencer.
// Assumes: burst order is a single-bit strap.
package bseq_pkg;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/bseq_start_reg.sv
// Module: holds the captured start address and the latched burst order.
// Assumes: order strap is stable after reset; load happens only with clk_en high.
module bseq_start_reg
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              load_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] start_q,
    output order_e            mode_q
);
    // Capture the start address on load and sample the order strap during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            mode_q  <= order_e'(order_sel);
        end else if (clk_en && !load_n) begin
            start_q <= ext_addr;
        end
    end
endmodule

// File: rtl/bseq_beat_ctr.sv
// Module: beat counter inside the burst window; wraps naturally at 2**BEAT_W.
// Assumes: load restarts the count at zero; frozen while clk_en is low.
module bseq_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              load_n,
    output logic [BEAT_W-1:0] beat_nxt
);
    logic [BEAT_W-1:0] beat_q;

    // Next beat: zero on load, otherwise one more modulo the window.
    always_comb begin
        beat_nxt = load_n ? beat_q + BEAT_W'(1) : '0;
    end

    // Hold the current beat number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (clk_en) begin
            beat_q <= beat_nxt;
        end
    end
endmodule

// File: rtl/bseq_order_gen.sv
// Module: combinational low-bit generator for linear or interleaved order.
// Assumes: beat is the number of beats past the start (0 = start itself).
module bseq_order_gen
    import bseq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat,
    input  order_e            mode,
    output logic [BEAT_W-1:0] lo_out
);
    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    // Linear order: modulo add of the beat to the start.
    always_comb begin
        lin_lo = start_lo + beat;
    end

    // Interleaved order: each bit of the start flipped by the matching beat bit.
    for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
        assign ilv_lo[i] = start_lo[i] ^ beat[i];
    end

    // Pick the order selected by the latched strap.
    always_comb begin
        lo_out = (mode == ORD_INTERLEAVE) ? ilv_lo : lin_lo;
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Module: top of the burst address sequencer; registers the beat address.
// Assumes: ADDR_W > BEAT_W; order strap static after reset.
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              load_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] burst_addr
);
    localparam int UP_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] start_q;
    order_e            mode_q;
    logic [BEAT_W-1:0] beat_nxt;
    logic [BEAT_W-1:0] lo_nxt;
    logic [ADDR_W-1:0] addr_q;

    bseq_start_reg #(.ADDR_W(ADDR_W)) u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .load_n    (load_n),
        .order_sel (order_sel),
        .ext_addr  (ext_addr),
        .start_q   (start_q),
        .mode_q    (mode_q)
    );

    bseq_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .load_n   (load_n),
        .beat_nxt (beat_nxt)
    );

    bseq_order_gen #(.BEAT_W(BEAT_W)) u_order (
        .start_lo (start_q[BEAT_W-1:0]),
        .beat     (beat_nxt),
        .mode     (mode_q),
        .lo_out   (lo_nxt)
    );

    // Output register: external address on load, next beat on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (clk_en) begin
            addr_q <= load_n ? {start_q[ADDR_W-1:ADDR_W-UP_W], lo_nxt} : ext_addr;
        end
    end

    assign burst_addr = addr_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
// Module: assertion checker for the burst address sequencer, bound to the top.
// Assumes: keeps its own record of the loaded start and the advances since.
module burst_addr_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              load_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] burst_addr,
    input logic              mode_q
);
    localparam int UP_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] seen_start;
    logic [BEAT_W-1:0] adv_cnt;

    // Track the start address and the advances since the last load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_start <= '0;
            adv_cnt    <= '0;
        end else if (clk_en) begin
            if (!load_n) begin
                seen_start <= ext_addr;
                adv_cnt    <= '0;
            end else begin
                adv_cnt <= adv_cnt + BEAT_W'(1);
            end
        end
    end

    AST_LOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && !load_n |=> burst_addr == $past(ext_addr)); // R2

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && load_n && !mode_q |=>
        burst_addr[BEAT_W-1:0] == BEAT_W'($past(burst_addr[BEAT_W-1:0]) + BEAT_W'(1))); // R3

    AST_INTERLEAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && load_n && mode_q |=>
        burst_addr[BEAT_W-1:0] ==
        ($past(seen_start[BEAT_W-1:0]) ^ BEAT_W'($past(adv_cnt) + BEAT_W'(1)))); // R4

    AST_WRAP_START: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && load_n && (adv_cnt == '1) |=> burst_addr == $past(seen_start)); // R5

    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && load_n |=>
        burst_addr[ADDR_W-1:ADDR_W-UP_W] == $past(seen_start[ADDR_W-1:ADDR_W-UP_W])); // R6

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(burst_addr)); // R7
endmodule

bind burst_addr_seq burst_addr_seq_chk #(
    .ADDR_W (ADDR_W),
    .BEAT_W (BEAT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .load_n     (load_n),
    .ext_addr   (ext_addr),
    .burst_addr (burst_addr),
    .mode_q     (mode_q)
);

// File: tb/burst_addr_seq_tb.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module burst_addr_seq_tb;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 20;
    localparam int BURST  = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              clk_en;
    logic              load_n;
    logic              order_sel;
    logic [ADDR_W-1:0] ext_addr;
    logic [ADDR_W-1:0] burst_addr;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    string cur_req = "R1";

    // Reference model state, all integers.
    int m_start = 0;
    int m_beat  = 0;
    int m_out   = 0;
    int m_mode  = 0;

    always #(CLK_P/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(2)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .load_n     (load_n),
        .order_sel  (order_sel),
        .ext_addr   (ext_addr),
        .burst_addr (burst_addr)
    );

    // Reference model, updated on each rising edge from the requirements.
    always @(posedge clk) begin
        int lo;
        if (!rst_n) begin
            m_start = 0; m_beat = 0; m_out = 0; m_mode = int'(order_sel);
        end else if (clk_en) begin
            if (!load_n) begin
                m_start = int'(ext_addr); m_beat = 0; m_out = m_start;
            end else begin
                m_beat = (m_beat + 1) % BURST;
                if (m_mode == 1) lo = (m_start % BURST) ^ m_beat;
                else             lo = ((m_start % BURST) + m_beat) % BURST;
                m_out = (m_start / BURST) * BURST + lo;
            end
        end
    end

    // Model compare on every falling edge once reset has been applied.
    always @(negedge clk) begin
        if (!done && $time > CLK_P * 2) begin
            n_chk++;
            if (int'(burst_addr) != m_out) begin
                n_fail++;
                $display("FAIL %s model: actual %h expected %h", cur_req, burst_addr, m_out[ADDR_W-1:0]);
            end
        end
    end

    task automatic check(input string req, input logic [ADDR_W-1:0] exp);
        n_chk++;
        if (burst_addr !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, burst_addr, exp);
        end
    endtask

    // Drive at a falling edge, then wait one cycle and check.
    task automatic cyc(input logic en, input logic ld_n, input logic [ADDR_W-1:0] a,
                       input string req, input logic [ADDR_W-1:0] exp);
        cur_req  = req;
        clk_en   = en;
        load_n   = ld_n;
        ext_addr = a;
        @(negedge clk);
        check(req, exp);
    endtask

    task automatic do_reset(input logic ord);
        cur_req   = "R1";
        rst_n     = 1'b0;
        order_sel = ord;
        clk_en    = 1'b1;
        load_n    = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; clk_en = 1'b0; load_n = 1'b1; order_sel = 1'b0; ext_addr = '0;
        @(negedge clk);
        do_reset(1'b0);
        // R1: beat cleared, so first advance from zero gives 1.
        cyc(1, 1, 20'h77777, "R1", 20'h00001);

        // R2 load then R3 linear, R6 ext_addr ignored, R5 wrap.
        cyc(1, 0, 20'h5A3C1, "R2", 20'h5A3C1);
        cyc(1, 1, 20'hFFFFF, "R3", 20'h5A3C2);
        cyc(1, 1, 20'h00000, "R6", 20'h5A3C3);
        cyc(1, 1, 20'h12345, "R3", 20'h5A3C0);
        cyc(1, 1, 20'hABCDE, "R5", 20'h5A3C1);
        cyc(1, 1, 20'h0F0F0, "R5", 20'h5A3C2);

        // R7: freeze with load pulses and new addresses.
        cyc(0, 0, 20'h11111, "R7", 20'h5A3C2);
        cyc(0, 1, 20'h22222, "R7", 20'h5A3C2);
        cyc(0, 0, 20'h33333, "R7", 20'h5A3C2);
        cyc(1, 1, 20'h44444, "R7", 20'h5A3C3);

        // R8: strap change after reset does not switch order.
        order_sel = 1'b1;
        cyc(1, 0, 20'h00AA1, "R2", 20'h00AA1);
        cyc(1, 1, 20'h00000, "R8", 20'h00AA2);
        cyc(1, 1, 20'h00000, "R8", 20'h00AA3);

        // Interleaved order selected at reset.
        @(negedge clk);
        do_reset(1'b1);
        order_sel = 1'b0;
        cyc(1, 0, 20'h12341, "R2", 20'h12341);
        cyc(1, 1, 20'h00000, "R4", 20'h12340);
        cyc(1, 1, 20'h00000, "R4", 20'h12343);
        cyc(1, 1, 20'h00000, "R4", 20'h12342);
        cyc(1, 1, 20'h00000, "R5", 20'h12341);
        cyc(1, 0, 20'h0FFF2, "R2", 20'h0FFF2);
        cyc(1, 1, 20'hFFFFF, "R4", 20'h0FFF3);
        cyc(0, 0, 20'h55555, "R7", 20'h0FFF3);
        cyc(1, 1, 20'h00000, "R4", 20'h0FFF0);
        cyc(1, 1, 20'h00000, "R8", 20'h0FFF1);
        cyc(1, 1, 20'h00000, "R5", 20'h0FFF2);
        // Reload mid-burst restarts the beat count.
        cyc(1, 1, 20'h00000, "R4", 20'h0FFF3);
        cyc(1, 0, 20'hC0003, "R2", 20'hC0003);
        cyc(1, 1, 20'h00000, "R4", 20'hC0002);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule